// File: doc/BRIEF.md
# Table-Driven Microcoded State Machine

This block is a sequencer with no next-state logic at all. A single synchronous table holds, for each combination of current state and control inputs, the successor state together with a pattern of free output bits. Every clock edge on which the machine runs performs one table read. The address of that read is the current state concatenated with the control inputs, so conditional branches are simply different table entries for the same state.

The read register of the table is itself the state register. As a result, the new state and the new outputs always appear together, one clock after their address was presented. Before the machine runs, a host or testbench fills the table through a simple write port. The balance between state bits and control-input bits is a parameter pair: more states means fewer control inputs for the same address width.

Top module: `ucode_fsm`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `stateOut` and `outBits` to zero. Both stay zero on later edges until the first edge with `run` high and `rst` low.
- R2: On an edge with `loadEn` high and `run` low, `loadData` is stored at table address `loadAddr`, and the state and outputs hold their values.
- R3: A write attempted while `run` is high is ignored. The table word at that address keeps its previous value.
- R4: On an edge with `run` high, the table is read at address `{stateOut, ctrlIn}`, with the state in the upper 6 bits and `ctrlIn` in the lower 4. After that edge, `stateOut` shows bits [17:12] of the word and `outBits` shows bits [11:0]. Both change on the same edge.
- R5: From the same state, different `ctrlIn` values select different table words, so a single state can branch to different successors.
- R6: With `run` and `rst` low, `stateOut` and `outBits` hold their values.
- R7: Reset takes priority over `run`. An edge with both high gives state zero and outputs zero.
- R8: All 64 states are reachable. A table chain 0→1→…→63→0 is followed step by step, and state 63 wraps to state 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Step the machine by one table lookup per edge |
| ctrlIn | input | 4 | Control inputs, already synchronised, low address bits |
| loadEn | input | 1 | Table write enable, honoured only while `run` is low |
| loadAddr | input | 10 | Table write address |
| loadData | input | 18 | Table write word: {next state[5:0], outputs[11:0]} |
| stateOut | output | 6 | Current state |
| outBits | output | 12 | Free output pattern of the last word read |

## Verification
The table has no read-back port. A stored word becomes visible only when the machine is steered into the matching state with the matching control value. The ignored-write case is the hardest to reach. The bench attempts a write while stepping, then resets to state zero and steps with the control value that selects the targeted word, which shows that the old contents survived. Reaching the wrap from state 63 needs a chain of 64 consecutive lookups. Each lookup in that chain is checked against a table model kept in the bench.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  // Strobes from the control decoder to the table datapath
  typedef struct packed {
    logic clear;   // force the read register to zero
    logic step;    // perform one table lookup
    logic write;   // store the load word into the table
  } strobe_t;
endpackage

// File: rtl/ucode_fsm_ctl.sv
module ucode_fsm_ctl
  import ucode_pkg::*;
(
  input  logic    rst,
  input  logic    run,
  input  logic    loadEn,
  output strobe_t strb
);
  // Reset dominates everything; writes only while the machine is parked
  always_comb begin
    strb.clear = rst;
    strb.step  = run & ~rst;
    strb.write = loadEn & ~run & ~rst;
  end
endmodule

// File: rtl/ucode_fsm_dp.sv
module ucode_fsm_dp
  import ucode_pkg::*;
#(
  parameter int STATE_W = 6,
  parameter int CTRL_W  = 4,
  parameter int OUT_W   = 12
) (
  input  logic                        clk,
  input  strobe_t                     strb,
  input  logic [CTRL_W-1:0]           ctrlIn,
  input  logic [STATE_W+CTRL_W-1:0]   loadAddr,
  input  logic [STATE_W+OUT_W-1:0]    loadData,
  output logic [STATE_W-1:0]          stateOut,
  output logic [OUT_W-1:0]            outBits
);
  localparam int ADDR_W = STATE_W + CTRL_W;
  localparam int WORD_W = STATE_W + OUT_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] tableMem [DEPTH];
  logic [WORD_W-1:0] rdWord;
  logic [ADDR_W-1:0] rdAddr;

  // State occupies the upper address bits, control inputs the lower
  assign rdAddr = {rdWord[WORD_W-1:OUT_W], ctrlIn};

  always_ff @(posedge clk) begin
    if (strb.write) tableMem[loadAddr] <= loadData;
  end

  // The read register doubles as the state register
  always_ff @(posedge clk) begin
    if (strb.clear)     rdWord <= '0;
    else if (strb.step) rdWord <= tableMem[rdAddr];
  end

  assign stateOut = rdWord[WORD_W-1:OUT_W];
  assign outBits  = rdWord[OUT_W-1:0];
endmodule

// File: rtl/ucode_fsm.sv
module ucode_fsm
  import ucode_pkg::*;
#(
  parameter int STATE_W = 6,
  parameter int CTRL_W  = 4,
  parameter int OUT_W   = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run,
  input  logic [CTRL_W-1:0]         ctrlIn,
  input  logic                      loadEn,
  input  logic [STATE_W+CTRL_W-1:0] loadAddr,
  input  logic [STATE_W+OUT_W-1:0]  loadData,
  output logic [STATE_W-1:0]        stateOut,
  output logic [OUT_W-1:0]          outBits
);
  strobe_t strb;

  ucode_fsm_ctl u_ctl (
    .rst    (rst),
    .run    (run),
    .loadEn (loadEn),
    .strb   (strb)
  );

  ucode_fsm_dp #(
    .STATE_W (STATE_W),
    .CTRL_W  (CTRL_W),
    .OUT_W   (OUT_W)
  ) u_dp (
    .clk      (clk),
    .strb     (strb),
    .ctrlIn   (ctrlIn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .stateOut (stateOut),
    .outBits  (outBits)
  );
endmodule

// File: rtl/ucode_fsm_chk.sv
module ucode_fsm_chk
  import ucode_pkg::*;
#(
  parameter int STATE_W = 6,
  parameter int OUT_W   = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               run,
  input logic               loadEn,
  input strobe_t            strb,
  input logic [STATE_W-1:0] stateOut,
  input logic [OUT_W-1:0]   outBits
);
  // R1: a reset edge leaves state and outputs at zero
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stateOut == '0 && outBits == '0));

  // R2: a table load does not disturb the state
  p_load_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (loadEn && !run) |=> $stable(stateOut) && $stable(outBits));

  // R3: the datapath never sees a write strobe while running
  p_no_write_running_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> !strb.write);

  // R6: parked machine holds state and outputs
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(stateOut) && $stable(outBits));

  // R7: reset wins over run
  p_reset_over_run_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst && run) |-> stateOut == '0);
endmodule

bind ucode_fsm ucode_fsm_chk #(
  .STATE_W (STATE_W),
  .OUT_W   (OUT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run),
  .loadEn   (loadEn),
  .strb     (strb),
  .stateOut (stateOut),
  .outBits  (outBits)
);

// File: tb/ucode_fsm_bench.sv
module ucode_fsm_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [3:0]  ctrlIn = '0;
  logic        loadEn = 1'b0;
  logic [9:0]  loadAddr = '0;
  logic [17:0] loadData = '0;
  logic [5:0]  stateOut;
  logic [11:0] outBits;

  ucode_fsm u_ucode_fsm (
    .clk(clk), .rst(rst), .run(run), .ctrlIn(ctrlIn),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .stateOut(stateOut), .outBits(outBits)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [5:0]  st;
    logic [11:0] o;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [17:0] model [1024];
  logic [5:0]  mSt = '0;
  logic [11:0] mOut = '0;
  int          nChecks = 0;
  int          nErr = 0;
  bit          finished = 0;

  // One cycle of stimulus; model updated per the requirements, expectation queued
  task automatic cyc(input bit r, input bit rn, input logic [3:0] c,
                     input bit le, input logic [9:0] a, input logic [17:0] d,
                     input string tag);
    logic [17:0] w;
    @(negedge clk);
    rst = r; run = rn; ctrlIn = c; loadEn = le; loadAddr = a; loadData = d;
    @(posedge clk);
    #1;
    if (r) begin
      mSt = '0; mOut = '0;
    end else if (rn) begin
      w = model[{mSt, c}];
      mSt = w[17:12]; mOut = w[11:0];
    end else if (le) begin
      model[a] = d;
    end
    expQ.push_back('{st: mSt, o: mOut, tag: tag});
  endtask

  // Scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        e = expQ.pop_front();
        nChecks++;
        if (stateOut !== e.st || outBits !== e.o) begin
          nErr++;
          $display("FAIL %s: state=%0d out=%h expected state=%0d out=%h",
                   e.tag, stateOut, outBits, e.st, e.o);
        end
      end
    end
  end

  function automatic logic [17:0] fillWord(input int a);
    logic [5:0]  s = 6'(a >> 4);
    logic [3:0]  c = 4'(a);
    logic [5:0]  nx = 6'(s + 6'd1 + 6'(c * 5));
    logic [11:0] o  = 12'((a * 37) ^ 12'hA5);
    return {nx, o};
  endfunction

  initial begin
    logic [3:0] c = 4'd7;
    // R1: reset state, then parked after reset
    cyc(1, 0, 0, 0, 0, 0, "R1");
    cyc(1, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, "R1");
    // R2: fill the whole table; state must hold on each load
    for (int a = 0; a < 1024; a++) cyc(0, 0, 0, 1, 10'(a), fillWord(a), "R2");
    // R4: run with a varied control sequence
    for (int i = 0; i < 80; i++) begin
      c = 4'(c * 5 + 3);
      cyc(0, 1, c, 0, 0, 0, "R4");
    end
    // R6: parked holds
    for (int i = 0; i < 4; i++) cyc(0, 0, 4'(i), 0, 0, 0, "R6");
    // R5: same state, two control values, two successors (1 and 26)
    cyc(1, 0, 0, 0, 0, 0, "R5");
    cyc(0, 1, 4'd0, 0, 0, 0, "R5");
    cyc(1, 0, 0, 0, 0, 0, "R5");
    cyc(0, 1, 4'd5, 0, 0, 0, "R5");
    // R7: reset while running
    cyc(0, 1, 4'd2, 0, 0, 0, "R7");
    cyc(1, 1, 4'd2, 0, 0, 0, "R7");
    // R8: walk 0..63 with ctrl 0 and wrap to 0
    for (int i = 0; i < 64; i++) cyc(0, 1, 4'd0, 0, 0, 0, "R8");
    if (mSt != 6'd0) begin
      nErr++; nChecks++;
      $display("FAIL R8: bench walk ended at %0d expected 0", mSt);
    end
    // R3: write attempted while running, then read that word back via state 0, ctrl 3
    cyc(0, 1, 4'd1, 1, {6'd0, 4'd3}, 18'h3F123, "R3");
    cyc(1, 0, 0, 0, 0, 0, "R3");
    cyc(0, 1, 4'd3, 0, 0, 0, "R3");
    // R2: a real load then readback at the same address
    cyc(0, 0, 0, 1, {6'd0, 4'd9}, 18'h2A5C3, "R2");
    cyc(1, 0, 0, 0, 0, 0, "R2");
    cyc(0, 1, 4'd9, 0, 0, 0, "R2");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL R4: watchdog expired, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule